// File: doc/BRIEF.md
# Transmit Three-Tap Emphasis Filter

This block shapes a serial NRZ bit stream, one bit per clock (one unit interval per clock), into a signed multi-bit drive level for a line driver or DAC. Each output sample is the sum of three weighted symbols. The pre-cursor tap looks at the bit that follows the current one. The main tap looks at the current bit. The post-cursor tap looks at the bit that came before. A bit of 1 counts as a +1 symbol and a bit of 0 as a -1 symbol, so each tap adds or subtracts its signed weight and no multiplier is needed. This lets the block apply de-emphasis against both leading and trailing inter-symbol interference.

Weights are loaded through a small write port with a select field. Typical use holds the main weight at full scale and fixes the pre-cursor weight, then sweeps the post-cursor weight. A built-in square-wave source can replace the data input. It produces runs of zeros and ones of equal length, so the low-frequency amplitude and the emphasis steps can be measured at the driver. The sum is clamped to the range of the output word.

Top module: `txfir_emph`

## Requirements
- R1: While rst_ni is low and after its release, with no weight written yet, the weights are pre = 0, main = 2^(W_W-1)-1, post = 0, both delay stages hold 0 bits (-1 symbols), and level_o reads -(2^(W_W-1)-1).
- R2: The input bit maps to a symbol before weighting: 1 gives +1 and 0 gives -1. With pre and post weights at zero, level_o equals +main or -main according to the bit.
- R3: A bit sampled at clock edge n contributes through the pre weight to the level registered at edge n, through the main weight at edge n+1, and through the post weight at edge n+2.
- R4: The level registered at edge n equals pre*s(n) + main*s(n-1) + post*s(n-2), where s(k) is the symbol of the bit sampled at edge k.
- R5: The sum is saturated to [-2^(OUT_W-1), 2^(OUT_W-1)-1]. It is never wrapped.
- R6: A write with coef_we_i high stores coef_wdata_i into the weight chosen by coef_sel_i (0 = pre, 1 = main, 2 = post) at that clock edge. The level registered at the following edge is the first to use the new weight, and all three weights in one sample come from one register set.
- R7: A write with coef_sel_i = 3 changes no weight.
- R8: While pat_en_i is high, bit_i is ignored and the filter input is a square wave. It is 0 for PAT_HALF edges and then 1 for PAT_HALF edges, repeating, and starts with zeros on the first edge at which pat_en_i is high. Dropping pat_en_i restarts the wave for the next enable.
- R9: Weights are two's-complement signed W_W-bit values, and negative weights (including -2^(W_W-1)) invert their tap's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | UI clock, one bit per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Serial NRZ data bit |
| pat_en_i | input | 1 | Select the internal square-wave source instead of bit_i |
| coef_we_i | input | 1 | Weight write strobe |
| coef_sel_i | input | 2 | Weight select: 0 pre, 1 main, 2 post, 3 none |
| coef_wdata_i | input | W_W | Signed weight value to write |
| level_o | output | OUT_W | Signed, saturated drive level |

## Verification
The bench builds the block with W_W = 6, PAT_HALF = 8 and a narrowed OUT_W = 7. With the default 8-bit output, three 6-bit weights can never leave the range. The 7-bit output lets full-scale weights of one sign push the sum to +93 or -96, so both saturation rails are exercised. The 16-edge square-wave period is short enough to cover several full cycles of the test pattern, including a restart after disable.

// File: rtl/txfir_pkg.sv
package txfir_pkg;

  localparam int SEL_W  = 2;
  localparam int N_TAPS = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_PRE  = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_POST = 2'd2,
    SEL_NONE = 2'd3
  } coef_sel_e;

endpackage

// File: rtl/txfir_coef_bank.sv
module txfir_coef_bank
  import txfir_pkg::*;
#(
  parameter int W_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic signed [W_W-1:0] wdata_i,
  output logic signed [W_W-1:0] w_pre_o,
  output logic signed [W_W-1:0] w_main_o,
  output logic signed [W_W-1:0] w_post_o
);

  localparam logic signed [W_W-1:0] W_MAX = W_W'((2 ** (W_W - 1)) - 1);

  logic signed [W_W-1:0] w_q [N_TAPS];

  for (genvar k = 0; k < N_TAPS; k++) begin : g_w
    localparam logic signed [W_W-1:0] RST_V = (k == int'(SEL_MAIN)) ? W_MAX : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              w_q[k] <= RST_V;
      else if (we_i && (sel_i == SEL_W'(k)))    w_q[k] <= wdata_i;
    end
  end

  assign w_pre_o  = w_q[int'(SEL_PRE)];
  assign w_main_o = w_q[int'(SEL_MAIN)];
  assign w_post_o = w_q[int'(SEL_POST)];

  AST_SEL_NONE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_NONE) |=> ($stable(w_pre_o) && $stable(w_main_o) && $stable(w_post_o))); // R7

  AST_MAIN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_MAIN) |=> (w_main_o == $past(wdata_i))); // R6

endmodule

// File: rtl/txfir_pattern_gen.sv
module txfir_pattern_gen #(
  parameter int HALF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic bit_o
);

  localparam int CNT_W = $clog2(2 * HALF);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(2 * HALF - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign bit_o = en_i && (cnt_q >= HALF_C);

  // level only flips at a half-period boundary
  AST_PAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && cnt_q != '0 && cnt_q != HALF_C) |-> (bit_o == $past(bit_o))); // R8

  AST_PAT_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !bit_o); // R8

endmodule

// File: rtl/txfir_delay_line.sv
module txfir_delay_line #(
  parameter int DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  output logic [DEPTH-1:0] taps_o
);

  logic [DEPTH-1:0] d_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q[k] <= 1'b0;
        else         d_q[k] <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) d_q[k] <= 1'b0;
        else         d_q[k] <= d_q[k-1];
      end
      AST_DELAY_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (d_q[k] == $past(d_q[k-1]))); // R3
    end
  end

  assign taps_o = d_q;

endmodule

// File: rtl/txfir_tap_sum.sv
module txfir_tap_sum
  import txfir_pkg::*;
#(
  parameter int W_W   = 6,
  parameter int OUT_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_TAPS-1:0]       sym_i,    // [2] pre, [1] main, [0] post
  input  logic signed [W_W-1:0]   w_pre_i,
  input  logic signed [W_W-1:0]   w_main_i,
  input  logic signed [W_W-1:0]   w_post_i,
  output logic signed [OUT_W-1:0] level_o
);

  localparam int SUM_W   = W_W + 2;
  localparam int RST_INT = -((2 ** (W_W - 1)) - 1);
  localparam logic signed [OUT_W-1:0] RST_LEVEL = OUT_W'(RST_INT);

  logic signed [W_W-1:0]   w_arr [N_TAPS];
  logic signed [SUM_W-1:0] sum_w;
  logic signed [OUT_W-1:0] sat_w;
  logic signed [OUT_W-1:0] level_q;

  assign w_arr[0] = w_post_i;
  assign w_arr[1] = w_main_i;
  assign w_arr[2] = w_pre_i;

  always_comb begin
    sum_w = '0;
    for (int k = 0; k < N_TAPS; k++) begin
      if (sym_i[k]) sum_w = sum_w + {{2{w_arr[k][W_W-1]}}, w_arr[k]};
      else          sum_w = sum_w - {{2{w_arr[k][W_W-1]}}, w_arr[k]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= RST_LEVEL;
    else         level_q <= sat_w;
  end

  if (OUT_W >= SUM_W) begin : g_wide
    assign sat_w = OUT_W'(sum_w);
  end else begin : g_sat
    localparam logic signed [SUM_W-1:0] OMAX = SUM_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] OMIN = SUM_W'(-(2 ** (OUT_W - 1)));

    always_comb begin
      if (sum_w > OMAX)      sat_w = OMAX[OUT_W-1:0];
      else if (sum_w < OMIN) sat_w = OMIN[OUT_W-1:0];
      else                   sat_w = sum_w[OUT_W-1:0];
    end

    AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_w > OMAX) |=> (level_q == OMAX[OUT_W-1:0])); // R5
    AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sum_w < OMIN) |=> (level_q == OMIN[OUT_W-1:0])); // R5
  end

  assign level_o = level_q;

endmodule

// File: rtl/txfir_emph.sv
module txfir_emph
  import txfir_pkg::*;
#(
  parameter int W_W      = 6,
  parameter int OUT_W    = 8,
  parameter int PAT_HALF = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             pat_en_i,
  input  logic             coef_we_i,
  input  logic [SEL_W-1:0] coef_sel_i,
  input  logic [W_W-1:0]   coef_wdata_i,
  output logic [OUT_W-1:0] level_o
);

  localparam int DLY = N_TAPS - 1;

  logic                    pat_bit;
  logic                    src_bit;
  logic [DLY-1:0]          dly_taps;
  logic signed [W_W-1:0]   w_pre, w_main, w_post;
  logic signed [OUT_W-1:0] level_s;

  txfir_pattern_gen #(.HALF(PAT_HALF)) u_pat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pat_en_i),
    .bit_o  (pat_bit)
  );

  // newest bit feeds the pre tap directly; registers hold main and post
  assign src_bit = pat_en_i ? pat_bit : bit_i;

  txfir_delay_line #(.DEPTH(DLY)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_bit),
    .taps_o (dly_taps)
  );

  txfir_coef_bank #(.W_W(W_W)) u_coef (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (coef_we_i),
    .sel_i    (coef_sel_i),
    .wdata_i  ($signed(coef_wdata_i)),
    .w_pre_o  (w_pre),
    .w_main_o (w_main),
    .w_post_o (w_post)
  );

  txfir_tap_sum #(.W_W(W_W), .OUT_W(OUT_W)) u_sum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sym_i    ({src_bit, dly_taps[0], dly_taps[DLY-1]}),
    .w_pre_i  (w_pre),
    .w_main_i (w_main),
    .w_post_i (w_post),
    .level_o  (level_s)
  );

  assign level_o = level_s;

  AST_PAT_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_en_i && !$rose(pat_en_i) && $past(pat_en_i)) |-> (src_bit == pat_bit)); // R8

endmodule

// File: tb/txfir_emph_tb_top.sv
`timescale 1ns/1ps
module txfir_emph_tb_top;

  localparam int W_W   = 6;
  localparam int OUT_W = 7;
  localparam int HALF  = 8;
  localparam int OMAX  = 63;
  localparam int OMIN  = -64;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             bit_i;
  logic             pat_en_i;
  logic             coef_we_i;
  logic [1:0]       coef_sel_i;
  logic [W_W-1:0]   coef_wdata_i;
  logic [OUT_W-1:0] level_o;

  always #2.5 clk = ~clk;

  txfir_emph #(.W_W(W_W), .OUT_W(OUT_W), .PAT_HALF(HALF)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bit_i        (bit_i),
    .pat_en_i     (pat_en_i),
    .coef_we_i    (coef_we_i),
    .coef_sel_i   (coef_sel_i),
    .coef_wdata_i (coef_wdata_i),
    .level_o      (level_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  // bench model state
  int wp, wm, wpo, pc;
  bit h0, h1;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int sg(bit b);
    return b ? 1 : -1;
  endfunction

  function automatic int clamp(int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: level got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit b, bit pat, bit we, int sel, int wd, string req);
    bit eff;
    int exp;
    eff          = pat ? (pc >= HALF) : b;
    bit_i        = b;
    pat_en_i     = pat;
    coef_we_i    = we;
    coef_sel_i   = 2'(sel);
    coef_wdata_i = W_W'(wd);
    @(posedge clk);
    #1;
    exp = clamp(sg(eff) * wp + sg(h0) * wm + sg(h1) * wpo);
    chk(req, int'($signed(level_o)), exp);
    h1 = h0;
    h0 = eff;
    pc = pat ? ((pc + 1) % (2 * HALF)) : 0;
    if (we) begin
      case (sel)
        0: wp  = wd;
        1: wm  = wd;
        2: wpo = wd;
        default: ;
      endcase
    end
    coef_we_i = 1'b0;
  endtask

  task automatic wr(int sel, int wd, bit b, string req);
    step(b, 1'b0, 1'b1, sel, wd, req);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; bit_i = 1'b0; pat_en_i = 1'b0;
    coef_we_i = 1'b0; coef_sel_i = '0; coef_wdata_i = '0;
    wp = 0; wm = 31; wpo = 0; pc = 0; h0 = 1'b0; h1 = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'($signed(level_o)), -31);
    rst_ni = 1'b1;
    #1;
    chk("R1", int'($signed(level_o)), -31);
    step(1'b0, 1'b0, 1'b0, 0, 0, "R1");
  endtask

  task automatic t_main_only();
    bit seq [6] = '{1, 1, 0, 1, 0, 0};
    foreach (seq[i]) step(seq[i], 1'b0, 1'b0, 0, 0, "R2");
  endtask

  task automatic t_latency();
    wr(0, 4, 1'b0, "R6");
    wr(1, 20, 1'b0, "R6");
    wr(2, -6, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R3");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R3");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R3");  // pre only: 4-20+6 = -10
    step(1'b0, 1'b0, 1'b0, 0, 0, "R3");  // main: -4+20+6 = 22
    step(1'b0, 1'b0, 1'b0, 0, 0, "R3");  // post: -4-20-6 = -30
    step(1'b0, 1'b0, 1'b0, 0, 0, "R3");
  endtask

  task automatic t_sum();
    wr(0, -9, 1'b1, "R6");
    wr(2, -13, 1'b0, "R6");
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], 1'b0, 1'b0, 0, 0, "R4");
    end
  endtask

  task automatic t_neg();
    wr(1, -20, 1'b1, "R9");
    wr(0, -32, 1'b0, "R9");
    wr(2, 15, 1'b1, "R9");
    for (int i = 0; i < 12; i++) step(bit'((i * 5 / 3) % 2), 1'b0, 1'b0, 0, 0, "R9");
  endtask

  task automatic t_sat();
    wr(0, 31, 1'b1, "R5");
    wr(1, 31, 1'b1, "R5");
    wr(2, 31, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R5");   // 93 -> 63
    step(1'b0, 1'b0, 1'b0, 0, 0, "R5");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R5");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R5");   // -93 -> -64
    wr(0, -32, 1'b0, "R5");
    wr(1, -32, 1'b0, "R5");
    wr(2, -32, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R5");   // 96 -> 63
    step(1'b1, 1'b0, 1'b0, 0, 0, "R5");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R5");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R5");   // -96 -> -64
  endtask

  task automatic t_write();
    wr(0, 0, 1'b1, "R6");
    wr(2, 0, 1'b1, "R6");
    wr(1, 10, 1'b1, "R6");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R6");   // new main 10 visible here
    wr(1, -25, 1'b1, "R6");               // old main still used this edge
    step(1'b0, 1'b0, 1'b0, 0, 0, "R6");
  endtask

  task automatic t_sel_none();
    wr(1, 17, 1'b1, "R7");
    wr(0, 3, 1'b1, "R7");
    step(1'b1, 1'b0, 1'b1, 3, -5, "R7");
    step(1'b0, 1'b0, 1'b1, 3, 21, "R7");
    for (int i = 0; i < 4; i++) step(bit'(i % 2), 1'b0, 1'b0, 0, 0, "R7");
  endtask

  task automatic t_pattern();
    wr(0, -4, 1'b1, "R8");
    wr(2, -7, 1'b1, "R8");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 0, 0, "R8");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R8");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 0, 0, "R8");
    step(1'b0, 1'b0, 1'b0, 0, 0, "R8");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL WDOG: run got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_main_only();
    t_latency();
    t_sum();
    t_neg();
    t_sat();
    t_write();
    t_sel_none();
    t_pattern();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule